// File: doc/BRIEF.md
# SGPIO Drive-LED Serial Transmitter

This block holds the drive-indicator state for every port of a small SATA host and sends it to an external LED controller. The link has three wires: a serial clock, a load strobe and serial data. A host-side request carries a port number and a 32-bit LED state word. The block takes the activity, locate and fault indications from fixed bits of that word and merges them into a stored pattern, three bits per port. It then sends one complete serial frame holding the whole pattern.

Each port's 3-bit group sits at a bit position chosen by a port-to-slot table, which can be rewritten through a configuration port. The length of each clock phase is a programmable number of system clock ticks, so a slow link (tens of microseconds per phase) can be produced from a fast core clock. While a frame is on the wire the request port reports not-ready, so one update can never be mixed into a frame already being sent. A request whose slot field or port number is out of range gets an error response and changes nothing.

Top module: `sgpio_led_tx`

## Requirements
- R1: After reset, `sgpio_clk`, `sgpio_load` and `sgpio_data` are high, `req_ready` is high, `rsp_valid` is low, and the stored pattern is all zeros.
- R2: A frame starts one cycle after a request is accepted. Load is high while the clock is high for H cycles and then low for H cycles. Load then falls in the same cycle that the clock rises for the first data bit.
- R3: After the load cycle, exactly 3×NUM_PORTS data bits follow, pattern bit 0 first. Each bit is put on `sgpio_data` in the cycle its clock rises and is held through H high cycles and H low cycles.
- R4: H is `cfg_half_val` written with `cfg_half_we`. A write of zero is ignored. H resets to DEF_HALF. The value in force when a request is accepted governs the whole of that frame.
- R5: Port p's group begins at pattern bit 3×slot(p). Any set bit of `req_state` under mask 0x0030_0000 sets group offset 2 (activity). Bit 19 (0x0008_0000) sets offset 1 (locate). Bit 22 (0x0040_0000) sets offset 0 (fault).
- R6: A `req_state` of exactly zero clears all three bits of the port's group. A nonzero word only sets bits and never clears bits set earlier.
- R7: The port-to-slot table resets to port0→4, port1→0, port2→1, port3→2, port4→3 (for NUM_PORTS=5, port0→NUM_PORTS-1 and portp→p-1 in general). A `cfg_map_we` write replaces one entry. A write whose port or slot is not below NUM_PORTS is ignored.
- R8: A request with `req_state[15:8]` ≥ MAX_EM_SLOTS, or with `req_port` ≥ NUM_PORTS, is rejected. The response shows `rsp_err`=1, the pattern is unchanged, no frame is sent and `req_ready` stays high.
- R9: `req_ready` falls the cycle after an accepted request and stays low until the last data bit's low half ends. `rsp_valid` pulses for one cycle right after any accepted request, with `rsp_err`=0 for a valid one.
- R10: Between frames all three link outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block can accept a request |
| req_port | input | PORT_W | Port the update is for |
| req_state | input | 32 | LED state word |
| rsp_valid | output | 1 | One-cycle response pulse after acceptance |
| rsp_err | output | 1 | Request was rejected |
| cfg_map_we | input | 1 | Write one port-to-slot entry |
| cfg_map_port | input | PORT_W | Entry to write |
| cfg_map_slot | input | SLOT_W | New slot for that port |
| cfg_half_we | input | 1 | Write half-period |
| cfg_half_val | input | HALF_W | Half-period in system clock cycles |
| sgpio_clk | output | 1 | Serial clock |
| sgpio_load | output | 1 | Frame load strobe |
| sgpio_data | output | 1 | Serial data |

## Verification
On every cycle the assertions check several local rules. A phase never ends before its tick count runs out. The load cycle hands over to bit 0 and the last bit returns to idle. Data stays stable through each bit. A zero word clears its group, a nonzero word only adds bits, and a reject leaves both the pattern and ready alone. Every table entry stays in range. Only the bench's scenarios can show that the right bit lands at the right serial position after decode and remapping, that H changes take effect exactly at the next accepted frame, and the exact cycle count of each frame. The bench does this by comparing every output against a behavioural model on every clock.

// File: rtl/sgpio_led_pkg.sv
package sgpio_led_pkg;

  localparam int GRP_BITS = 3;
  localparam int OFF_ACT  = 2;
  localparam int OFF_LOC  = 1;
  localparam int OFF_FLT  = 0;

  localparam logic [31:0] ACT_MASK = 32'h0030_0000;
  localparam logic [31:0] LOC_MASK = 32'h0008_0000;
  localparam logic [31:0] FLT_MASK = 32'h0040_0000;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOAD_HI,
    PH_LOAD_LO,
    PH_BIT_HI,
    PH_BIT_LO
  } phase_t;

  typedef struct packed {
    logic clr;
    logic act;
    logic loc;
    logic flt;
  } led_ind_t;

  // Pull the three indications (and the clear case) out of a state word.
  function automatic led_ind_t decode_word(input logic [31:0] w);
    led_ind_t d;
    d.clr = (w == 32'h0);
    d.act = |(w & ACT_MASK);
    d.loc = |(w & LOC_MASK);
    d.flt = |(w & FLT_MASK);
    return d;
  endfunction

  // Place the indications at their offsets inside a 3-bit group.
  function automatic logic [GRP_BITS-1:0] group_bits(input led_ind_t d);
    logic [GRP_BITS-1:0] g;
    g          = '0;
    g[OFF_ACT] = d.act;
    g[OFF_LOC] = d.loc;
    g[OFF_FLT] = d.flt;
    return g;
  endfunction

  // Zero word clears the group, anything else only ORs bits in.
  function automatic logic [GRP_BITS-1:0] group_next(input logic [GRP_BITS-1:0] cur,
                                                     input led_ind_t d);
    return d.clr ? '0 : (cur | group_bits(d));
  endfunction

  // Reset mapping: port0 takes the top slot, the others shift down by one.
  function automatic int unsigned default_slot(input int unsigned port,
                                               input int unsigned n);
    return (port == 0) ? (n - 1) : (port - 1);
  endfunction

  function automatic logic slot_field_ok(input logic [31:0] w, input int unsigned max);
    return {24'h0, w[15:8]} < max;
  endfunction

endpackage

// File: rtl/sgpio_slot_map.sv
module sgpio_slot_map
  import sgpio_led_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PORT_W-1:0] rd_port,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              rd_port_ok
);

  logic [SLOT_W-1:0] map_q [NUM_PORTS];
  logic              wr_ok;

  assign wr_ok = wr_en && (32'(wr_port) < 32'(NUM_PORTS))
                       && (32'(wr_slot) < 32'(NUM_PORTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++)
        map_q[p] <= SLOT_W'(default_slot(p, NUM_PORTS));
    end else if (wr_ok) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (wr_port == PORT_W'(p)) map_q[p] <= wr_slot;
    end
  end

  always_comb begin
    rd_slot = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_port == PORT_W'(p)) rd_slot = map_q[p];
  end

  assign rd_port_ok = 32'(rd_port) < 32'(NUM_PORTS);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_MAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(map_q[p]) < 32'(NUM_PORTS)); // R7
  end

endmodule

// File: rtl/sgpio_pattern_reg.sv
module sgpio_pattern_reg
  import sgpio_led_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int SLOT_W    = 3,
  localparam int PAT_W    = GRP_BITS * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [SLOT_W-1:0] slot,
  input  led_ind_t          ind,
  output logic [PAT_W-1:0]  pat_q
);

  int unsigned grp_base;

  assign grp_base = GRP_BITS * 32'(slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
    end else if (upd_en) begin
      for (int g = 0; g < NUM_PORTS; g++)
        if (slot == SLOT_W'(g))
          pat_q[GRP_BITS*g +: GRP_BITS] <= group_next(pat_q[GRP_BITS*g +: GRP_BITS], ind);
    end
  end

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && ind.clr) |=> (pat_q[$past(grp_base) +: GRP_BITS] == '0)); // R6
  AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !ind.clr) |=> ((pat_q & $past(pat_q)) == $past(pat_q))); // R6
  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(pat_q)); // R8

endmodule

// File: rtl/sgpio_frame_seq.sv
module sgpio_frame_seq
  import sgpio_led_pkg::*;
#(
  parameter int              PAT_W    = 15,
  parameter int              HALF_W   = 16,
  parameter logic [HALF_W-1:0] DEF_HALF = 16'd2500,
  localparam int             BIT_W    = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAT_W-1:0]  pattern,
  input  logic              cfg_half_we,
  input  logic [HALF_W-1:0] cfg_half_val,
  output logic              idle,
  output logic              sclk,
  output logic              sload,
  output logic              sdata
);

  phase_t            phase;
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_cfg_q;
  logic [HALF_W-1:0] half_run_q;
  logic [BIT_W-1:0]  bit_q;
  logic [PAT_W-1:0]  shift_q;
  logic              phase_done;
  logic              last_bit;

  assign phase_done = (cnt_q == half_run_q - HALF_W'(1));
  assign last_bit   = (bit_q == BIT_W'(PAT_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_cfg_q <= DEF_HALF;
    else if (cfg_half_we && cfg_half_val != '0) half_cfg_q <= cfg_half_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt_q      <= '0;
      half_run_q <= DEF_HALF;
      bit_q      <= '0;
      shift_q    <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase      <= PH_START;
          half_run_q <= half_cfg_q;
        end
        PH_START: begin
          shift_q <= pattern;
          cnt_q   <= '0;
          phase   <= PH_LOAD_HI;
        end
        PH_LOAD_HI: begin
          if (phase_done) begin cnt_q <= '0; phase <= PH_LOAD_LO; end
          else cnt_q <= cnt_q + HALF_W'(1);
        end
        PH_LOAD_LO: begin
          if (phase_done) begin cnt_q <= '0; bit_q <= '0; phase <= PH_BIT_HI; end
          else cnt_q <= cnt_q + HALF_W'(1);
        end
        PH_BIT_HI: begin
          if (phase_done) begin cnt_q <= '0; phase <= PH_BIT_LO; end
          else cnt_q <= cnt_q + HALF_W'(1);
        end
        PH_BIT_LO: begin
          if (phase_done) begin
            cnt_q <= '0;
            if (last_bit) phase <= PH_IDLE;
            else begin
              bit_q   <= bit_q + BIT_W'(1);
              shift_q <= shift_q >> 1;
              phase   <= PH_BIT_HI;
            end
          end else cnt_q <= cnt_q + HALF_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle  = (phase == PH_IDLE);
  assign sclk  = !(phase == PH_LOAD_LO || phase == PH_BIT_LO);
  assign sload = !(phase == PH_BIT_HI || phase == PH_BIT_LO);
  assign sdata = (phase == PH_BIT_HI || phase == PH_BIT_LO) ? shift_q[0] : 1'b1;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_START && !phase_done) |=> (phase == $past(phase))); // R4
  AST_LOAD_THEN_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD_LO && phase_done) |=> (phase == PH_BIT_HI && bit_q == '0)); // R2
  AST_LAST_BIT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BIT_LO && phase_done && last_bit) |=> (phase == PH_IDLE)); // R3
  AST_DATA_STABLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BIT_HI) |=> $stable(sdata)); // R3

endmodule

// File: rtl/sgpio_led_tx.sv
module sgpio_led_tx
  import sgpio_led_pkg::*;
#(
  parameter int                NUM_PORTS    = 5,
  parameter int                MAX_EM_SLOTS = 8,
  parameter int                HALF_W       = 16,
  parameter logic [HALF_W-1:0] DEF_HALF     = 16'd2500,
  localparam int               PORT_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int               SLOT_W       = PORT_W,
  localparam int               PAT_W        = GRP_BITS * NUM_PORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic [31:0]       req_state,
  output logic              rsp_valid,
  output logic              rsp_err,
  input  logic              cfg_map_we,
  input  logic [PORT_W-1:0] cfg_map_port,
  input  logic [SLOT_W-1:0] cfg_map_slot,
  input  logic              cfg_half_we,
  input  logic [HALF_W-1:0] cfg_half_val,
  output logic              sgpio_clk,
  output logic              sgpio_load,
  output logic              sgpio_data
);

  logic [SLOT_W-1:0] slot;
  logic              port_ok;
  logic              req_fire;
  logic              req_ok;
  logic              upd_en;
  logic              reject;
  logic [PAT_W-1:0]  pattern;
  led_ind_t          ind;

  assign req_fire = req_valid && req_ready;
  assign req_ok   = port_ok && slot_field_ok(req_state, MAX_EM_SLOTS);
  assign upd_en   = req_fire && req_ok;
  assign reject   = req_fire && !req_ok;
  assign ind      = decode_word(req_state);

  sgpio_slot_map #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .SLOT_W(SLOT_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_map_we), .wr_port(cfg_map_port), .wr_slot(cfg_map_slot),
    .rd_port(req_port), .rd_slot(slot), .rd_port_ok(port_ok)
  );

  sgpio_pattern_reg #(
    .NUM_PORTS(NUM_PORTS), .SLOT_W(SLOT_W)
  ) u_pat (
    .clk(clk), .rst_n(rst_n),
    .upd_en(upd_en), .slot(slot), .ind(ind), .pat_q(pattern)
  );

  sgpio_frame_seq #(
    .PAT_W(PAT_W), .HALF_W(HALF_W), .DEF_HALF(DEF_HALF)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(upd_en), .pattern(pattern),
    .cfg_half_we(cfg_half_we), .cfg_half_val(cfg_half_val),
    .idle(req_ready), .sclk(sgpio_clk), .sload(sgpio_load), .sdata(sgpio_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_fire;
      rsp_err   <= reject;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (!req_ready && rsp_valid && !rsp_err)); // R9
  AST_REJECT_STAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (req_ready && rsp_valid && rsp_err)); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sgpio_clk && sgpio_load && sgpio_data)); // R10

endmodule

// File: tb/tb_sgpio_led_tx.sv
module tb_sgpio_led_tx;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_port = '0;
  logic [31:0] req_state = '0;
  logic        rsp_valid, rsp_err;
  logic        cfg_map_we = 1'b0;
  logic [2:0]  cfg_map_port = '0;
  logic [2:0]  cfg_map_slot = '0;
  logic        cfg_half_we = 1'b0;
  logic [15:0] cfg_half_val = '0;
  logic        sgpio_clk, sgpio_load, sgpio_data;

  int tests = 0;
  int fails = 0;

  // Behavioural model state
  logic [5:0] exp_q[$];   // {ready, sclk, load, data, rsp_valid, rsp_err}
  string      tag_q[$];
  int         map_m[NP];
  logic [14:0] pat_m;
  int         half_m;
  string      cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgpio_led_tx #(.NUM_PORTS(NP), .MAX_EM_SLOTS(8), .HALF_W(16), .DEF_HALF(16'd4)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port), .req_state(req_state),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .cfg_map_we(cfg_map_we), .cfg_map_port(cfg_map_port), .cfg_map_slot(cfg_map_slot),
    .cfg_half_we(cfg_half_we), .cfg_half_val(cfg_half_val),
    .sgpio_clk(sgpio_clk), .sgpio_load(sgpio_load), .sgpio_data(sgpio_data)
  );

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t {rdy,clk,load,data,rv,re} actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Every-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] e;
      string t;
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = 6'b111100;
        t = "R10";
      end
      check(t, {req_ready, sgpio_clk, sgpio_load, sgpio_data, rsp_valid, rsp_err}, e);
    end
  end

  task automatic push(logic [5:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic push_frame(logic [14:0] p, int h);
    push(6'b011110, "R9");
    for (int i = 0; i < h; i++) push(6'b011100, "R2");
    for (int i = 0; i < h; i++) push(6'b001100, "R2");
    for (int b = 0; b < 3*NP; b++) begin
      for (int i = 0; i < h; i++) push({3'b010, p[b], 2'b00}, cur_tag);
      for (int i = 0; i < h; i++) push({3'b000, p[b], 2'b00}, cur_tag);
    end
  endtask

  task automatic wait_idle();
    @(posedge clk);
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic send(int port, logic [31:0] st, string t);
    int pos;
    cur_tag = t;
    wait_idle();
    req_valid = 1'b1;
    req_port  = 3'(port);
    req_state = st;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    if (port < NP && st[15:8] < 8) begin
      pos = 3 * map_m[port];
      if (st == 0) begin
        pat_m[pos] = 1'b0; pat_m[pos+1] = 1'b0; pat_m[pos+2] = 1'b0;
      end else begin
        if ((st & 32'h0030_0000) != 0) pat_m[pos+2] = 1'b1;
        if (st[19]) pat_m[pos+1] = 1'b1;
        if (st[22]) pat_m[pos] = 1'b1;
      end
      push_frame(pat_m, half_m);
    end else begin
      push(6'b111111, "R8");
    end
  endtask

  task automatic set_map(int port, int slot);
    @(posedge clk); #1;
    cfg_map_we = 1'b1; cfg_map_port = 3'(port); cfg_map_slot = 3'(slot);
    @(posedge clk); #1;
    cfg_map_we = 1'b0;
    if (port < NP && slot < NP) map_m[port] = slot;
  endtask

  task automatic set_half(int h);
    @(posedge clk); #1;
    cfg_half_we = 1'b1; cfg_half_val = 16'(h);
    @(posedge clk); #1;
    cfg_half_we = 1'b0;
    if (h != 0) half_m = h;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    map_m = '{4, 0, 1, 2, 3};
    pat_m = '0;
    half_m = 4;
    cur_tag = "R3";
    #(CLK_PERIOD * 3 + 2);
    // R1: reset values while reset is held
    check("R1", {req_ready, sgpio_clk, sgpio_load, sgpio_data, rsp_valid, rsp_err}, 6'b111100);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1/R3: first frame shows an all-zero pattern apart from the one update (default H=4, R4)
    send(1, 32'h0008_0000, "R1");           // locate, port1 -> slot0 -> bit1 (R5, R7)
    set_half(2);                              // R4
    set_half(0);                              // R4: zero ignored
    send(0, 32'h0010_0000, "R5");           // activity via 0x100000, port0 -> slot4 -> bit14
    send(2, 32'h0060_0000, "R5");           // fault + activity, slot1 -> bits 3,5
    send(2, 32'h0008_0000, "R6");           // adds locate bit4, keeps 3,5
    send(2, 32'h0000_0000, "R6");           // zero clears bits 3..5
    send(3, 32'h0008_0800, "R8");           // slot field 8 -> rejected
    send(5, 32'h0040_0000, "R8");           // port 5 -> rejected
    send(4, 32'h0020_0000, "R8");           // frame after rejects: pattern unchanged by them
    set_map(3, 4);                            // R7
    set_map(6, 0);                            // R7: bad port ignored
    set_map(1, 5);                            // R7: bad slot ignored
    send(3, 32'h0040_0000, "R7");           // fault to slot4 -> bit12
    send(1, 32'h0080_0000, "R7");           // no indication bits: still slot0, no change
    set_half(3);                              // during frame: next frame uses 3 (R4)
    send(4, 32'h0000_0000, "R4");           // clears slot3 with H=3
    send(0, 32'h0040_0700, "R3");           // slot field 7 accepted, fault bit12
    wait_idle();
    repeat (5) @(posedge clk);
    #1;
    check("R10", {req_ready, sgpio_clk, sgpio_load, sgpio_data, rsp_valid, rsp_err}, 6'b111100);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule